// File: doc/BRIEF.md
# Two-Wire Serial Register Slave

This block is the control port of a multi-lane device. It listens on a two-wire serial bus as a slave only. It samples both bus lines on a fast system clock and finds START, repeated START and STOP. It compares the first byte of each transfer with its own 7-bit address. Software then writes a register pointer and any number of data bytes, or reads back bytes starting at the pointer. The block answers by pulling SDA low through an open-drain enable. It never drives SDA high.

The address is four fixed upper bits followed by three strap pins. The register file holds these registers:
- one general byte and one lane-enable byte;
- a control byte and an enable byte for each lane, spaced three addresses apart;
- two reserved read/write bytes;
- a fixed read-only identification byte.

All writable bytes appear on output ports and drive the lane hardware. The active-low power-down pin passes through the same synchronizer as the bus lines. While it is low, the serial state returns to idle and every writable register is cleared.

The controller has nine states:
- `ST_IDLE`: waits for START. STOP, power-down and an address mismatch all lead here.
- `ST_DEV`: shifts in the address byte. Any START enters this state.
- `ST_DEV_ACK`: acknowledges a matched address. It then goes to `ST_RD` when the direction bit is 1, or to `ST_PTR` when it is 0.
- `ST_PTR`: shifts in the pointer byte.
- `ST_PTR_ACK`: acknowledges the pointer byte, then goes to `ST_WR`.
- `ST_WR`: shifts in a data byte.
- `ST_WR_ACK`: acknowledges the data byte, then returns to `ST_WR`.
- `ST_RD`: shifts out a byte, most significant bit first.
- `ST_RD_ACK`: samples the master's acknowledge. An ACK leads back to `ST_RD`; a NACK leads to `ST_IDLE`.

Every transition between bit states happens on a detected SCL falling edge.

Top module: `twi_regfile_slave`

## Requirements
- R1: The block responds only to the 7-bit address {0000, strap_addr[2:0]}. For any other address it answers NACK and never asserts sda_oe during that transfer.
- R2: The slave acknowledges by holding SDA low through the ninth clock after a matched address byte, after a pointer byte and after every written data byte.
- R3: A write transfer has this form: START, address with direction bit 0, pointer byte, then data bytes. Each data byte is stored at the pointer, and the pointer then increments. Reserved registers 0x11 and 0x12 can be read and written.
- R4: A read (direction bit 1) returns the register at the pointer, most significant bit first, and increments the pointer. A master NACK after a byte ends the transfer.
- R5: A repeated START restarts address decode without a STOP. This allows a pointer write followed by a read.
- R6: After STOP the block ignores bus clocks until the next START.
- R7: After reset every writable register is 0x00, and register 0x0F reads 0x30.
- R8: Writes to 0x0F or to an unmapped address are acknowledged but change nothing. Unmapped addresses read 0x00.
- R9: While pd_n is low, all writable registers clear and the interface returns to idle. If the clear and a data-byte commit fall in the same cycle, the clear wins. The next transfer works normally.
- R10: sda_oe changes only while SCL is low, so that SDA hold time is met.
- R11: Lane i has its control byte at 0x02+3i and its enable byte at 0x03+3i. The bytes appear on cfg_lane_ctl[8i+7:8i] and cfg_lane_ena[8i+7:8i]. Register 0x00 drives cfg_general and register 0x01 drives cfg_lane_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_n | input | 1 | Active-low power-down; clears registers and the bus state |
| strap_addr | input | 3 | Low three bits of the slave address |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_general | output | 8 | Register 0x00 |
| cfg_lane_en | output | 8 | Register 0x01 |
| cfg_lane_ctl | output | 8*NLANE | Per-lane control bytes |
| cfg_lane_ena | output | 8*NLANE | Per-lane enable bytes |

## Verification
Power-down and a data-byte commit can land in the same cycle. pd_n and SCL pass through the same synchronizer, so they do. The bench provokes this by lowering SCL for the eighth data bit and lowering pd_n at the same clock edge. The detected falling edge and the power-down then reach the state machine together. The result is judged at the ports: every configuration output must read zero afterwards. A following transfer must then read 0x30 from 0x0F and 0x00 from the register that was being written.

// File: rtl/twi_pkg.sv
package twi_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } twi_state_e;

    localparam logic [3:0] BYTE_BITS = 4'd8;

endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '1;
        end else begin
            stage_q[0] <= d;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/twi_regs.sv
module twi_regs #(
    parameter int         NLANE       = 4,
    parameter logic [7:0] GEN_ADDR    = 8'h00,
    parameter logic [7:0] LEN_ADDR    = 8'h01,
    parameter int         LANE_BASE   = 2,
    parameter int         LANE_STRIDE = 3,
    parameter logic [7:0] RO_ADDR     = 8'h0F,
    parameter logic [7:0] RO_VALUE    = 8'h30,
    parameter logic [7:0] RSV_A_ADDR  = 8'h11,
    parameter logic [7:0] RSV_B_ADDR  = 8'h12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               we,
    input  logic [7:0]         waddr,
    input  logic [7:0]         wdata,
    input  logic [7:0]         raddr,
    output logic [7:0]         rdata,
    output logic [7:0]         gen_o,
    output logic [7:0]         laneen_o,
    output logic [NLANE*8-1:0] lane_ctl_o,
    output logic [NLANE*8-1:0] lane_ena_o
);
    localparam int LW = NLANE * 8;

    logic [7:0] gen_q, laneen_q, rsva_q, rsvb_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            gen_q    <= '0;
            laneen_q <= '0;
            rsva_q   <= '0;
            rsvb_q   <= '0;
        end else if (we) begin
            if (waddr == GEN_ADDR)   gen_q    <= wdata;
            if (waddr == LEN_ADDR)   laneen_q <= wdata;
            if (waddr == RSV_A_ADDR) rsva_q   <= wdata;
            if (waddr == RSV_B_ADDR) rsvb_q   <= wdata;
        end
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam logic [7:0] CTL_A = 8'(LANE_BASE + g * LANE_STRIDE);
        localparam logic [7:0] ENA_A = 8'(LANE_BASE + g * LANE_STRIDE + 1);
        logic [7:0] ctl_q, ena_q;

        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                ctl_q <= '0;
                ena_q <= '0;
            end else if (we) begin
                if (waddr == CTL_A) ctl_q <= wdata;
                if (waddr == ENA_A) ena_q <= wdata;
            end
        end

        assign lane_ctl_o[g*8 +: 8] = ctl_q;
        assign lane_ena_o[g*8 +: 8] = ena_q;
    end

    always_comb begin
        rdata = '0;
        if (raddr == GEN_ADDR)   rdata = gen_q;
        if (raddr == LEN_ADDR)   rdata = laneen_q;
        if (raddr == RSV_A_ADDR) rdata = rsva_q;
        if (raddr == RSV_B_ADDR) rdata = rsvb_q;
        if (raddr == RO_ADDR)    rdata = RO_VALUE;
        for (int i = 0; i < NLANE; i++) begin
            if (raddr == 8'(LANE_BASE + i * LANE_STRIDE))     rdata = lane_ctl_o[i*8 +: 8];
            if (raddr == 8'(LANE_BASE + i * LANE_STRIDE + 1)) rdata = lane_ena_o[i*8 +: 8];
        end
    end

    assign gen_o    = gen_q;
    assign laneen_o = laneen_q;

    // R9: a clear empties every writable byte on the next cycle
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (gen_q == 8'h00 && laneen_q == 8'h00 && rsva_q == 8'h00 &&
                 rsvb_q == 8'h00 && lane_ctl_o == LW'(0) && lane_ena_o == LW'(0)));

    // R8: a write aimed at the read-only byte leaves all storage untouched
    a_r8_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr && waddr == RO_ADDR) |=>
            $stable({gen_q, laneen_q, rsva_q, rsvb_q, lane_ctl_o, lane_ena_o}));

endmodule

// File: rtl/twi_regfile_slave.sv
module twi_regfile_slave
    import twi_pkg::*;
#(
    parameter int         NLANE       = 4,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] ADDR_HI     = 4'b0000,
    parameter int         LANE_BASE   = 2,
    parameter int         LANE_STRIDE = 3,
    parameter logic [7:0] RO_ADDR     = 8'h0F,
    parameter logic [7:0] RO_VALUE    = 8'h30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pd_n,
    input  logic [2:0]         strap_addr,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    output logic [7:0]         cfg_general,
    output logic [7:0]         cfg_lane_en,
    output logic [NLANE*8-1:0] cfg_lane_ctl,
    output logic [NLANE*8-1:0] cfg_lane_ena
);
    logic [2:0] sync_q;
    logic       scl_s, sda_s, pd_s, scl_d, sda_d;
    logic       scl_rise, scl_fall, start_det, stop_det;

    twi_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pd_n, sda_i, scl_i}),
        .q     (sync_q)
    );
    assign {pd_s, sda_s, scl_s} = sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

    twi_state_e st, st_nx;
    logic [3:0] bit_q;
    logic [7:0] shreg_q, ptr_q, tx_q, rdata;
    logic       rw_q, nack_q, byte_done, dev_hit, wr_commit, ack_state;

    assign byte_done = (bit_q == BYTE_BITS);
    assign dev_hit   = (shreg_q[7:1] == {ADDR_HI, strap_addr});
    assign wr_commit = pd_s && scl_fall && byte_done && (st == ST_WR);
    assign ack_state = (st == ST_DEV_ACK) || (st == ST_PTR_ACK) ||
                       (st == ST_WR_ACK)  || (st == ST_RD_ACK);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        if (!pd_s)           st_nx = ST_IDLE;
        else if (start_det)  st_nx = ST_DEV;
        else if (stop_det)   st_nx = ST_IDLE;
        else if (scl_fall) begin
            unique case (st)
                ST_IDLE:    st_nx = ST_IDLE;
                ST_DEV:     if (byte_done) st_nx = dev_hit ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK: st_nx = rw_q ? ST_RD : ST_PTR;
                ST_PTR:     if (byte_done) st_nx = ST_PTR_ACK;
                ST_PTR_ACK: st_nx = ST_WR;
                ST_WR:      if (byte_done) st_nx = ST_WR_ACK;
                ST_WR_ACK:  st_nx = ST_WR;
                ST_RD:      if (byte_done) st_nx = ST_RD_ACK;
                ST_RD_ACK:  st_nx = nack_q ? ST_IDLE : ST_RD;
                default:    st_nx = ST_IDLE;
            endcase
        end
    end

    // datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n || !pd_s) begin
            bit_q   <= '0;
            shreg_q <= '0;
            ptr_q   <= '0;
            tx_q    <= '0;
            rw_q    <= 1'b0;
            nack_q  <= 1'b1;
        end else if (start_det) begin
            bit_q <= '0;
        end else if (scl_rise && st != ST_IDLE) begin
            shreg_q <= {shreg_q[6:0], sda_s};
            bit_q   <= bit_q + 4'd1;
            if (st == ST_RD_ACK) nack_q <= sda_s;
        end else if (scl_fall) begin
            if (byte_done || ack_state) bit_q <= '0;
            unique case (st)
                ST_DEV:     if (byte_done) rw_q <= shreg_q[0];
                ST_DEV_ACK: if (rw_q) begin
                                tx_q  <= rdata;
                                ptr_q <= ptr_q + 8'd1;
                            end
                ST_PTR:     if (byte_done) ptr_q <= shreg_q;
                ST_WR:      if (byte_done) ptr_q <= ptr_q + 8'd1;
                ST_RD:      if (!byte_done) tx_q <= {tx_q[6:0], 1'b0};
                ST_RD_ACK:  if (!nack_q) begin
                                tx_q  <= rdata;
                                ptr_q <= ptr_q + 8'd1;
                            end
                default:    ;
            endcase
        end
    end

    always_comb begin
        unique case (st)
            ST_DEV_ACK, ST_PTR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD:                             sda_oe = ~tx_q[7];
            default:                           sda_oe = 1'b0;
        endcase
    end

    twi_regs #(
        .NLANE       (NLANE),
        .LANE_BASE   (LANE_BASE),
        .LANE_STRIDE (LANE_STRIDE),
        .RO_ADDR     (RO_ADDR),
        .RO_VALUE    (RO_VALUE)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (~pd_s),
        .we         (wr_commit),
        .waddr      (ptr_q),
        .wdata      (shreg_q),
        .raddr      (ptr_q),
        .rdata      (rdata),
        .gen_o      (cfg_general),
        .laneen_o   (cfg_lane_en),
        .lane_ctl_o (cfg_lane_ctl),
        .lane_ena_o (cfg_lane_ena)
    );

    // R10: the open-drain enable only moves while SCL is low
    a_r10_sda_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_s && $past(pd_s) && sda_oe != $past(sda_oe)) |-> !scl_s);

    // R6: STOP returns the controller to idle
    a_r6_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_s && stop_det) |=> (st == ST_IDLE));

    // R9: power-down forces idle and releases SDA
    a_r9_pd_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_s |=> (st == ST_IDLE && !sda_oe));

    // R4: a master NACK ends the read
    a_r4_nack_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_s && scl_fall && st == ST_RD_ACK && nack_q) |=> (st == ST_IDLE));

    // R3: each committed data byte advances the pointer by one
    a_r3_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> (ptr_q == $past(ptr_q) + 8'd1));

endmodule

// File: tb/twi_regfile_slave_bench.sv
`timescale 1ns/1ps
module twi_regfile_slave_bench;
    localparam int NL = 4;
    localparam int Q  = 6;

    logic clk = 1'b0, rst_n = 1'b0, pd_n = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic sda_oe;
    logic sda_bus;
    logic [7:0] cfg_general, cfg_lane_en;
    logic [NL*8-1:0] cfg_lane_ctl, cfg_lane_ena;

    assign sda_bus = sda_m & ~sda_oe;
    always #2.5 clk = ~clk;

    twi_regfile_slave u_twi_regfile_slave (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .strap_addr(strap),
        .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .cfg_general(cfg_general), .cfg_lane_en(cfg_lane_en),
        .cfg_lane_ctl(cfg_lane_ctl), .cfg_lane_ena(cfg_lane_ena)
    );

    int n_chk = 0, n_bad = 0;
    int hold_viol = 0, mis_drive = 0;
    bit watch_mis = 1'b0;
    bit done = 1'b0;
    logic prev_oe = 1'b0;
    logic [7:0] exp_q [$];
    logic [7:0] act_q [$];
    string      tag_q [$];
    logic [7:0] buf_d [16];
    logic [7:0] exp_d [16];
    logic [6:0] cur_dev = 7'h05;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start;
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic m_stop;
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
    endtask

    task automatic m_bit_out(input logic b);
        sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic m_bit_in(output logic b);
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); b = sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic m_byte_out(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) m_bit_out(v[i]);
        m_bit_in(b);
        ack = ~b;
    endtask

    task automatic m_byte_in(output logic [7:0] v, input logic nack);
        for (int i = 7; i >= 0; i--) m_bit_in(v[i]);
        m_bit_out(nack);
    endtask

    task automatic do_write(input logic [6:0] dev, input logic [7:0] ptr, input int n,
                            input bit exp_ack, input string tag);
        logic a;
        m_start;
        m_byte_out({dev, 1'b0}, a);
        chk(a == exp_ack, {tag, " address ack"}, a, exp_ack);
        if (a) begin
            m_byte_out(ptr, a);
            chk(a, {tag, " pointer ack R2"}, a, 1);
            for (int i = 0; i < n; i++) begin
                m_byte_out(buf_d[i], a);
                chk(a, {tag, " data ack R2"}, a, 1);
            end
        end
        m_stop;
    endtask

    task automatic do_read(input logic [7:0] ptr, input int n, input string tag);
        logic a;
        logic [7:0] v;
        m_start;
        m_byte_out({cur_dev, 1'b0}, a);
        m_byte_out(ptr, a);
        m_start;
        m_byte_out({cur_dev, 1'b1}, a);
        chk(a, {tag, " read address ack R5"}, a, 1);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(exp_d[i]);
            tag_q.push_back(tag);
            m_byte_in(v, (i == n - 1));
            act_q.push_back(v);
        end
        m_stop;
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] a, e;
                string t;
                a = act_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(a == e, {t, " read data"}, a, e);
            end
        end
    end

    // R10 and R1 observers
    always @(negedge clk) begin
        if (rst_n && pd_n) begin
            if (sda_oe !== prev_oe && scl_m) hold_viol <= hold_viol + 1;
            if (watch_mis && sda_oe) mis_drive <= mis_drive + 1;
        end
        prev_oe <= sda_oe;
    end

    task automatic finish_run;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            finish_run;
        end
    end

    initial begin
        logic a;
        wq(10);
        rst_n = 1'b1;
        wq(5);
        // R7 reset state
        chk(cfg_general == 8'h00, "R7 general reset", cfg_general, 0);
        chk(cfg_lane_en == 8'h00, "R7 lane-enable reset", cfg_lane_en, 0);
        chk(cfg_lane_ctl == '0 && cfg_lane_ena == '0, "R7 lane reset", {cfg_lane_ctl, cfg_lane_ena}, 0);
        chk(sda_oe == 1'b0, "R10 released at reset", sda_oe, 0);

        // R7, R8: read-only id and unmapped/reserved reads
        exp_d[0] = 8'h30; exp_d[1] = 8'h00; exp_d[2] = 8'h00; exp_d[3] = 8'h00;
        do_read(8'h0F, 4, "R7 id and defaults");

        // R3, R11: burst write to general registers
        buf_d[0] = 8'hA5; buf_d[1] = 8'h3C;
        do_write(cur_dev, 8'h00, 2, 1'b1, "R3 write general");
        chk(cfg_general == 8'hA5, "R11 cfg_general", cfg_general, 8'hA5);
        chk(cfg_lane_en == 8'h3C, "R3 auto-increment lane-enable", cfg_lane_en, 8'h3C);

        // R11: lane registers across unmapped gaps
        for (int i = 0; i < 11; i++) buf_d[i] = 8'(8'h10 + i);
        do_write(cur_dev, 8'h02, 11, 1'b1, "R11 lane burst");
        chk(cfg_lane_ctl == 32'h19161310, "R11 lane control map", cfg_lane_ctl, 32'h19161310);
        chk(cfg_lane_ena == 32'h1A171411, "R11 lane enable map", cfg_lane_ena, 32'h1A171411);

        // R4, R5: multi-byte read after repeated START
        exp_d[0] = 8'hA5; exp_d[1] = 8'h3C; exp_d[2] = 8'h10;
        exp_d[3] = 8'h11; exp_d[4] = 8'h00; exp_d[5] = 8'h13;
        do_read(8'h00, 6, "R4 burst read");

        // R8, R3: read-only and unmapped writes, reserved read/write
        buf_d[0] = 8'h77; buf_d[1] = 8'hFF; buf_d[2] = 8'h55; buf_d[3] = 8'hAA; buf_d[4] = 8'hBB;
        do_write(cur_dev, 8'h0E, 5, 1'b1, "R8 ignored writes");
        exp_d[0] = 8'h00; exp_d[1] = 8'h30; exp_d[2] = 8'h00; exp_d[3] = 8'hAA; exp_d[4] = 8'hBB;
        do_read(8'h0E, 5, "R8 readback");

        // R1: foreign addresses
        watch_mis = 1'b1;
        buf_d[0] = 8'h00;
        do_write(7'h06, 8'h00, 1, 1'b0, "R1 low-bit mismatch");
        do_write(7'h0D, 8'h00, 1, 1'b0, "R1 high-bit mismatch");
        watch_mis = 1'b0;
        chk(mis_drive == 0, "R1 no drive on mismatch", mis_drive, 0);
        chk(cfg_general == 8'hA5, "R1 register untouched", cfg_general, 8'hA5);

        // R6: bytes after STOP without START are ignored
        m_byte_out({cur_dev, 1'b0}, a);
        chk(a == 1'b0, "R6 no ack without START", a, 0);
        m_byte_out(8'h00, a);
        m_byte_out(8'h00, a);
        m_stop;
        chk(cfg_general == 8'hA5, "R6 register untouched", cfg_general, 8'hA5);

        // R1: strap change moves the address
        strap = 3'b010; cur_dev = 7'h02;
        wq(4);
        buf_d[0] = 8'h5A;
        do_write(cur_dev, 8'h01, 1, 1'b1, "R1 new strap");
        chk(cfg_lane_en == 8'h5A, "R1 write at new address", cfg_lane_en, 8'h5A);

        // R9: power-down lands on the data commit cycle
        m_start;
        m_byte_out({cur_dev, 1'b0}, a);
        m_byte_out(8'h00, a);
        for (int i = 0; i < 7; i++) m_bit_out(1'b1);
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(2*Q);
        scl_m = 1'b0; pd_n = 1'b0;
        wq(10);
        pd_n = 1'b1;
        wq(Q);
        scl_m = 1'b1;
        wq(2*Q);
        chk(cfg_general == 8'h00 && cfg_lane_en == 8'h00, "R9 general cleared",
            {cfg_general, cfg_lane_en}, 0);
        chk(cfg_lane_ctl == '0 && cfg_lane_ena == '0, "R9 lanes cleared",
            {cfg_lane_ctl, cfg_lane_ena}, 0);
        exp_d[0] = 8'h30;
        do_read(8'h0F, 1, "R9 recovers id");
        exp_d[0] = 8'h00;
        do_read(8'h00, 1, "R9 cleared readback");

        wq(20);
        chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
        chk(hold_viol == 0, "R10 SDA only moves with SCL low", hold_viol, 0);
        done = 1'b1;
        finish_run;
    end

endmodule